// File: doc/BRIEF.md
# Two-Channel DAC Write-Frame Decoder

This block sits behind an I2C byte-level receiver. It takes single-cycle event strobes for a START, an address byte, a data byte and a STOP, together with the byte that came with the event. From these it decodes write frames aimed at a two-channel DAC. The target address matches when it is the broadcast value or when it encodes, in base 3, the same three-level states as the block's strap inputs. Each strap can be tied low, left floating or tied high. The decoded strap states of every received non-broadcast address are shown on an output.

After an accepted address, the first data byte carries a command and a channel select. The bytes after it arrive in pairs, high byte first. Each pair forms a left-justified 16-bit word. The word is aligned to the converter resolution, which is set by a parameter (12, 14 or 16 bits), and is then applied to the selected channels. Each channel holds an input register, an output register and a power-down flag.

Top module: `dacfd_top`

## Requirements
- R1: After reset, the following outputs read zero: `in_a`, `in_b`, `out_a`, `out_b`, `pd`, `err`, `code` and `rx_global`. `rx_strap` reads 6'h3F.
- R2: When the block is waiting for an address and an address event arrives, `rx_strap` updates on the next cycle. The 7-bit address is taken from ev_byte[6:0]. Bits 6,5,4,1,0 are packed (in that order) into a 5-bit value v. For 4 <= v <= 30, t = v-4, and t is written as three base-3 digits. Digit t/9 goes to rx_strap[5:4], (t/3)%3 goes to [3:2], and t%3 goes to [1:0]. Each digit is 0 for low, 1 for floating and 2 for high. For any other v, and for the broadcast address, `rx_strap` is 6'h3F.
- R3: The address 7'h73 sets `rx_global` and is always accepted. Any other address is accepted only if its digits equal `strap`, which uses the same layout as `rx_strap`. After an address is rejected, every byte is ignored until the next START.
- R4: The command byte holds the command in bits 7:4 and the channel select in bits 3:0. If either code is not listed, `err` is set and the data of that frame is discarded. The next valid command byte clears `err`.
- R5: Data bytes pair up high byte first. A pair is applied when its second byte arrives. Further pairs reuse the same command. An unpaired byte before STOP is discarded.
- R6: The applied value, and the `code` output, is the 16-bit word shifted right by 16-RES_BITS. `code` updates on every completed pair of a valid frame.
- R7: Command 0x0 loads the selected input registers.
- R8: Command 0x1 copies each selected input register into its output register. The data word is not stored.
- R9: Command 0x3 loads both the input and the output register of each selected channel and clears its power-down flag.
- R10: Command 0x4 sets the selected power-down flags. Command 0xF changes nothing. `pd[0]` is channel A and `pd[1]` is channel B.
- R11: Channel select 0x0 is A, 0x1 is B, and 0xF is both.
- R12: The block leaves idle only on START. In each state, any event other than the expected one is ignored, with two exceptions: STOP ends the data phase, and a START at any point restarts decoding at the address step. Registers, `err` and `code` change only in a cycle that follows a data event.

Parameter: `RES_BITS` (12, 14 or 16, default 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap | input | 6 | Own strap states {CA2,CA1,CA0}, 2 bits each, values 0..2 |
| ev_start | input | 1 | START event strobe |
| ev_addr_wr | input | 1 | Address-write byte strobe |
| ev_data_wr | input | 1 | Data-write byte strobe |
| ev_stop | input | 1 | STOP event strobe |
| ev_byte | input | 8 | Byte accompanying address/data strobes |
| rx_strap | output | 6 | Decoded strap states of last received address |
| rx_global | output | 1 | Last received address was the broadcast one |
| err | output | 1 | Last command byte was invalid |
| code | output | RES_BITS | Last aligned data word |
| in_a | output | RES_BITS | Channel A input register |
| in_b | output | RES_BITS | Channel B input register |
| out_a | output | RES_BITS | Channel A output register |
| out_b | output | RES_BITS | Channel B output register |
| pd | output | 2 | Power-down flags {B,A} |

## Verification
The properties assume that at most one event strobe is high in any cycle, since the front end reports bus events one at a time. They also assume that `strap` holds only digit values 0 to 2. The bench raises each strobe for one cycle with idle cycles in between, and changes `strap` only while no frame is in progress. Under these conditions the hold properties can tie every change of register, flag or code to a preceding data event.

// File: rtl/dacfd_pkg.sv
package dacfd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_SKIP
    } fsm_e;

    localparam logic [3:0] CMD_WR_IN  = 4'h0;
    localparam logic [3:0] CMD_UPD    = 4'h1;
    localparam logic [3:0] CMD_WR_UP  = 4'h3;
    localparam logic [3:0] CMD_PWR_DN = 4'h4;
    localparam logic [3:0] CMD_NOP    = 4'hF;

    localparam logic [3:0] SEL_A  = 4'h0;
    localparam logic [3:0] SEL_B  = 4'h1;
    localparam logic [3:0] SEL_AB = 4'hF;

    localparam logic [6:0] GLOBAL_ADDR = 7'h73;
    localparam logic [5:0] STRAP_NONE  = 6'h3F;
    localparam int         WORD_W      = 16;
    localparam int         NUM_CH      = 2;
endpackage

// File: rtl/dacfd_addr_dec.sv
module dacfd_addr_dec
    import dacfd_pkg::*;
(
    input  logic [6:0] addr,
    output logic [5:0] digits,
    output logic       is_global
);
    logic [4:0] packed_v;
    logic [4:0] tern;

    always_comb begin
        packed_v  = {addr[6:4], addr[1:0]};
        tern      = packed_v - 5'd4;
        is_global = (addr == GLOBAL_ADDR);
        if (is_global || packed_v < 5'd4 || packed_v > 5'd30) begin
            digits = STRAP_NONE;
        end else begin
            digits = {2'(tern / 5'd9), 2'((tern / 5'd3) % 5'd3), 2'(tern % 5'd3)};
        end
    end
endmodule

// File: rtl/dacfd_cmd_dec.sv
module dacfd_cmd_dec
    import dacfd_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output logic [3:0] cmd,
    output logic [1:0] sel,
    output logic       valid
);
    logic cmd_ok;

    always_comb begin
        cmd = cmd_byte[7:4];
        unique case (cmd)
            CMD_WR_IN, CMD_UPD, CMD_WR_UP, CMD_PWR_DN, CMD_NOP: cmd_ok = 1'b1;
            default: cmd_ok = 1'b0;
        endcase
        unique case (cmd_byte[3:0])
            SEL_A:   sel = 2'b01;
            SEL_B:   sel = 2'b10;
            SEL_AB:  sel = 2'b11;
            default: sel = 2'b00;
        endcase
        valid = cmd_ok && (sel != 2'b00);
    end
endmodule

// File: rtl/dacfd_chan.sv
module dacfd_chan
    import dacfd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic [3:0]   cmd,
    input  logic [W-1:0] value,
    output logic [W-1:0] in_reg,
    output logic [W-1:0] out_reg,
    output logic         pd
);
    typedef struct packed {
        logic [W-1:0] in_v;
        logic [W-1:0] out_v;
        logic         pd;
    } chan_s;

    chan_s ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (hit) begin
            unique case (cmd)
                CMD_WR_IN: ch_d.in_v = value;
                CMD_UPD:   ch_d.out_v = ch_q.in_v;
                CMD_WR_UP: begin
                    ch_d.in_v  = value;
                    ch_d.out_v = value;
                    ch_d.pd    = 1'b0;
                end
                CMD_PWR_DN: ch_d.pd = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign in_reg  = ch_q.in_v;
    assign out_reg = ch_q.out_v;
    assign pd      = ch_q.pd;
endmodule

// File: rtl/dacfd_top.sv
module dacfd_top
    import dacfd_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [5:0]          strap,
    input  logic                ev_start,
    input  logic                ev_addr_wr,
    input  logic                ev_data_wr,
    input  logic                ev_stop,
    input  logic [7:0]          ev_byte,
    output logic [5:0]          rx_strap,
    output logic                rx_global,
    output logic                err,
    output logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] in_a,
    output logic [RES_BITS-1:0] in_b,
    output logic [RES_BITS-1:0] out_a,
    output logic [RES_BITS-1:0] out_b,
    output logic [1:0]          pd
);
    localparam int W       = RES_BITS;
    localparam int SHIFT_N = WORD_W - RES_BITS;

    typedef struct packed {
        fsm_e         state;
        logic [7:0]   hi;
        logic         have_hi;
        logic [3:0]   cmd;
        logic [1:0]   sel;
        logic         err;
        logic [5:0]   rx_strap;
        logic         rx_global;
        logic [W-1:0] code;
    } top_s;

    top_s r_d, r_q;

    logic [5:0]        dig_w;
    logic              glob_w;
    logic [3:0]        cmd_w;
    logic [1:0]        sel_w;
    logic              cmd_ok_w;
    logic [WORD_W-1:0] word_w;
    logic [W-1:0]      value_w;
    logic              apply_w;

    dacfd_addr_dec u_addr (
        .addr      (ev_byte[6:0]),
        .digits    (dig_w),
        .is_global (glob_w)
    );

    dacfd_cmd_dec u_cmd (
        .cmd_byte (ev_byte),
        .cmd      (cmd_w),
        .sel      (sel_w),
        .valid    (cmd_ok_w)
    );

    always_comb begin
        word_w  = {r_q.hi, ev_byte};
        value_w = W'(word_w >> SHIFT_N);
        apply_w = !ev_start && ev_data_wr && (r_q.state == ST_DATA) && r_q.have_hi;
    end

    always_comb begin
        r_d = r_q;
        if (ev_start) begin
            r_d.state   = ST_ADDR;
            r_d.have_hi = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR: if (ev_addr_wr) begin
                    r_d.rx_strap  = dig_w;
                    r_d.rx_global = glob_w;
                    r_d.state = (glob_w || (dig_w != STRAP_NONE && dig_w == strap))
                              ? ST_CMD : ST_SKIP;
                end
                ST_CMD: if (ev_data_wr) begin
                    r_d.err     = !cmd_ok_w;
                    r_d.cmd     = cmd_w;
                    r_d.sel     = sel_w;
                    r_d.have_hi = 1'b0;
                    r_d.state   = cmd_ok_w ? ST_DATA : ST_SKIP;
                end
                ST_DATA: begin
                    if (ev_data_wr) begin
                        if (!r_q.have_hi) begin
                            r_d.hi      = ev_byte;
                            r_d.have_hi = 1'b1;
                        end else begin
                            r_d.have_hi = 1'b0;
                            r_d.code    = value_w;
                        end
                    end else if (ev_stop) begin
                        r_d.have_hi = 1'b0;
                        r_d.state   = ST_IDLE;
                    end
                end
                ST_SKIP: if (ev_stop) r_d.state = ST_IDLE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.rx_strap <= STRAP_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    logic [W-1:0] in_w  [NUM_CH];
    logic [W-1:0] out_w [NUM_CH];
    logic [1:0]   pd_w;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dacfd_chan #(.W(W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (apply_w && r_q.sel[ch]),
            .cmd     (r_q.cmd),
            .value   (value_w),
            .in_reg  (in_w[ch]),
            .out_reg (out_w[ch]),
            .pd      (pd_w[ch])
        );
    end

    assign rx_strap  = r_q.rx_strap;
    assign rx_global = r_q.rx_global;
    assign err       = r_q.err;
    assign code      = r_q.code;
    assign in_a      = in_w[0];
    assign in_b      = in_w[1];
    assign out_a     = out_w[0];
    assign out_b     = out_w[1];
    assign pd        = pd_w;
endmodule

// File: rtl/dacfd_chk.sv
module dacfd_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ev_start,
    input logic         ev_addr_wr,
    input logic         ev_data_wr,
    input logic         ev_stop,
    input logic [5:0]   rx_strap,
    input logic         rx_global,
    input logic         err,
    input logic [W-1:0] code,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic [W-1:0] out_a,
    input logic [W-1:0] out_b,
    input logic [1:0]   pd
);
    p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_addr_wr, ev_data_wr, ev_stop}));

    p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strap != 6'h3F |-> (rx_strap[5:4] != 2'd3 && rx_strap[3:2] != 2'd3
                               && rx_strap[1:0] != 2'd3));

    p_global_digits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_global |-> rx_strap == 6'h3F);

    p_err_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_data_wr |=> !$rose(err));

    p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_data_wr |=> $stable(code));

    p_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_data_wr |=> ($stable(in_a) && $stable(in_b)));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_data_wr |=> ($stable(out_a) && $stable(out_b)));

    p_pd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_data_wr |=> $stable(pd));
endmodule

bind dacfd_top dacfd_chk #(.W(RES_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_addr_wr (ev_addr_wr),
    .ev_data_wr (ev_data_wr),
    .ev_stop    (ev_stop),
    .rx_strap   (rx_strap),
    .rx_global  (rx_global),
    .err        (err),
    .code       (code),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_a      (out_a),
    .out_b      (out_b),
    .pd         (pd)
);

// File: tb/tb_dacfd_top.sv
module tb_dacfd_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] strap = 6'b01_10_00;
    logic       ev_start = 1'b0, ev_addr_wr = 1'b0, ev_data_wr = 1'b0, ev_stop = 1'b0;
    logic [7:0] ev_byte = 8'h00;

    logic [5:0]  rx_strap, rs14, rs12;
    logic        rx_global, rg14, rg12, err, er14, er12;
    logic [15:0] code, in_a, in_b, out_a, out_b;
    logic [13:0] code14, ia14, ib14, oa14, ob14;
    logic [11:0] code12, ia12, ib12, oa12, ob12;
    logic [1:0]  pd, pd14, pd12;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dacfd_top #(.RES_BITS(16)) dut (.clk, .rst_n, .strap, .ev_start, .ev_addr_wr,
        .ev_data_wr, .ev_stop, .ev_byte, .rx_strap, .rx_global, .err, .code,
        .in_a, .in_b, .out_a, .out_b, .pd);
    dacfd_top #(.RES_BITS(14)) dut14 (.clk, .rst_n, .strap, .ev_start, .ev_addr_wr,
        .ev_data_wr, .ev_stop, .ev_byte, .rx_strap(rs14), .rx_global(rg14), .err(er14),
        .code(code14), .in_a(ia14), .in_b(ib14), .out_a(oa14), .out_b(ob14), .pd(pd14));
    dacfd_top #(.RES_BITS(12)) dut12 (.clk, .rst_n, .strap, .ev_start, .ev_addr_wr,
        .ev_data_wr, .ev_stop, .ev_byte, .rx_strap(rs12), .rx_global(rg12), .err(er12),
        .code(code12), .in_a(ia12), .in_b(ib12), .out_a(oa12), .out_b(ob12), .pd(pd12));

    localparam int K_START = 0, K_ADDR = 1, K_DATA = 2, K_STOP = 3;

    // stimulus: {expected err, command byte, data word}
    localparam int NV = 13;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h00, 16'h1234}, {1'b0, 8'h01, 16'hABCD}, {1'b0, 8'h1F, 16'h0000},
        {1'b0, 8'h3F, 16'hFFFF}, {1'b0, 8'h40, 16'h0000}, {1'b0, 8'h41, 16'h0000},
        {1'b0, 8'h30, 16'h8001}, {1'b0, 8'h0F, 16'h5A5A}, {1'b0, 8'h11, 16'h0000},
        {1'b0, 8'hF0, 16'h7777}, {1'b1, 8'h20, 16'h9999}, {1'b1, 8'h05, 16'h4444},
        {1'b0, 8'h00, 16'h0102}
    };

    logic [15:0] m_in [2];
    logic [15:0] m_out [2];
    logic [1:0]  m_pd;
    logic [15:0] m_word;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(int kind, logic [7:0] b);
        @(negedge clk);
        ev_byte    = b;
        ev_start   = (kind == K_START);
        ev_addr_wr = (kind == K_ADDR);
        ev_data_wr = (kind == K_DATA);
        ev_stop    = (kind == K_STOP);
        @(negedge clk);
        ev_start = 1'b0; ev_addr_wr = 1'b0; ev_data_wr = 1'b0; ev_stop = 1'b0;
    endtask

    function automatic logic [6:0] addr_of(int c2, int c1, int c0);
        logic [4:0] v;
        v = 5'(9 * c2 + 3 * c1 + c0 + 4);
        return {v[4:2], 2'b00, v[1:0]};
    endfunction

    task automatic model_apply(logic [7:0] cb, logic [15:0] w);
        logic [1:0] s;
        s = (cb[3:0] == 4'h0) ? 2'b01 : (cb[3:0] == 4'h1) ? 2'b10 : 2'b11;
        m_word = w;
        for (int c = 0; c < 2; c++) begin
            if (s[c]) begin
                case (cb[7:4])
                    4'h0: m_in[c] = w;
                    4'h1: m_out[c] = m_in[c];
                    4'h3: begin m_in[c] = w; m_out[c] = w; m_pd[c] = 1'b0; end
                    4'h4: m_pd[c] = 1'b1;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic check_regs(string tag);
        check({tag, " in_a"},  32'(in_a),  32'(m_in[0]));
        check({tag, " in_b"},  32'(in_b),  32'(m_in[1]));
        check({tag, " out_a"}, 32'(out_a), 32'(m_out[0]));
        check({tag, " out_b"}, 32'(out_b), 32'(m_out[1]));
        check({tag, " pd"},    32'(pd),    32'(m_pd));
    endtask

    task automatic frame(logic [6:0] a, logic [7:0] cb, logic [15:0] w);
        pulse(K_START, 8'h00);
        pulse(K_ADDR, {1'b0, a});
        pulse(K_DATA, cb);
        pulse(K_DATA, w[15:8]);
        pulse(K_DATA, w[7:0]);
        pulse(K_STOP, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R12 act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] own;
        own = addr_of(1, 2, 0);
        m_in = '{16'h0, 16'h0}; m_out = '{16'h0, 16'h0}; m_pd = 2'b00; m_word = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_regs("R1");
        check("R1 err", 32'(err), 0);
        check("R1 code", 32'(code), 0);
        check("R1 rx_strap", 32'(rx_strap), 32'h3F);
        check("R1 rx_global", 32'(rx_global), 0);

        // R12 events in idle are ignored
        pulse(K_ADDR, {1'b0, own});
        pulse(K_DATA, 8'h00);
        pulse(K_DATA, 8'h12);
        pulse(K_DATA, 8'h34);
        check_regs("R12 idle");
        check("R12 idle rx_strap", 32'(rx_strap), 32'h3F);

        // table walk: R4..R11
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            frame(own, v[23:16], v[15:0]);
            if (!v[24]) model_apply(v[23:16], v[15:0]);
            check_regs("R7 R8 R9 R10 R11 vec");
            check("R4 err", 32'(err), 32'(v[24]));
            check("R6 code16", 32'(code), 32'(m_word));
            check("R6 code14", 32'(code14), 32'(m_word >> 2));
            check("R6 code12", 32'(code12), 32'(m_word >> 4));
        end

        // R2 R3: every strap combination, matching and non-matching
        for (int c2 = 0; c2 < 3; c2++) begin
            for (int c1 = 0; c1 < 3; c1++) begin
                for (int c0 = 0; c0 < 3; c0++) begin
                    logic [15:0] w;
                    int n0;
                    w = {8'(9 * c2 + 3 * c1 + c0), 8'hA5};
                    n0 = (c0 + 1) % 3;
                    strap = {2'(c2), 2'(c1), 2'(c0)};
                    frame(addr_of(c2, c1, c0), 8'h00, w);
                    model_apply(8'h00, w);
                    check("R2 rx_strap", 32'(rx_strap), 32'({2'(c2), 2'(c1), 2'(c0)}));
                    check("R3 match in_a", 32'(in_a), 32'(m_in[0]));
                    frame(addr_of(c2, c1, n0), 8'h00, ~w);
                    check("R2 rx_strap other", 32'(rx_strap), 32'({2'(c2), 2'(c1), 2'(n0)}));
                    check("R3 mismatch in_a", 32'(in_a), 32'(m_in[0]));
                end
            end
        end
        strap = 6'b01_10_00;

        // R3 broadcast address
        frame(7'h73, 8'h01, 16'hC3C3);
        model_apply(8'h01, 16'hC3C3);
        check("R3 global flag", 32'(rx_global), 1);
        check("R3 global digits", 32'(rx_strap), 32'h3F);
        check("R3 global in_b", 32'(in_b), 32'(m_in[1]));

        // R2 out-of-range packed value
        frame(7'h00, 8'h00, 16'h1111);
        check("R2 range digits", 32'(rx_strap), 32'h3F);
        check("R2 range ignored", 32'(in_a), 32'(m_in[0]));

        // R5 odd trailing byte, then multiple pairs
        pulse(K_START, 8'h00); pulse(K_ADDR, {1'b0, own}); pulse(K_DATA, 8'h00);
        pulse(K_DATA, 8'h2B); pulse(K_DATA, 8'h3C); pulse(K_DATA, 8'hEE);
        pulse(K_STOP, 8'h00);
        model_apply(8'h00, 16'h2B3C);
        check("R5 odd in_a", 32'(in_a), 32'(m_in[0]));
        pulse(K_START, 8'h00); pulse(K_ADDR, {1'b0, own}); pulse(K_DATA, 8'h01);
        pulse(K_DATA, 8'h11); pulse(K_DATA, 8'h22);
        model_apply(8'h01, 16'h1122);
        check("R5 first pair", 32'(in_b), 32'(m_in[1]));
        pulse(K_DATA, 8'h33); pulse(K_DATA, 8'h44); pulse(K_STOP, 8'h00);
        model_apply(8'h01, 16'h3344);
        check("R5 second pair", 32'(in_b), 32'(m_in[1]));

        // R12 repeated start mid-pair
        pulse(K_START, 8'h00); pulse(K_ADDR, {1'b0, own}); pulse(K_DATA, 8'h00);
        pulse(K_DATA, 8'h99);
        frame(own, 8'h01, 16'h5566);
        model_apply(8'h01, 16'h5566);
        check("R12 restart in_a", 32'(in_a), 32'(m_in[0]));
        check("R12 restart in_b", 32'(in_b), 32'(m_in[1]));

        // R12 stop ignored while waiting for command byte
        pulse(K_START, 8'h00); pulse(K_ADDR, {1'b0, own}); pulse(K_STOP, 8'h00);
        pulse(K_DATA, 8'h00); pulse(K_DATA, 8'h0A); pulse(K_DATA, 8'h0B);
        pulse(K_STOP, 8'h00);
        model_apply(8'h00, 16'h0A0B);
        check("R12 stop in cmd", 32'(in_a), 32'(m_in[0]));

        // R4 err cleared by next valid command
        frame(own, 8'h2F, 16'h1);
        check("R4 err set", 32'(err), 1);
        frame(own, 8'hF1, 16'h2);
        model_apply(8'hF1, 16'h2);
        check("R4 err clear", 32'(err), 0);
        check_regs("R10 nop");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule